// File: doc/BRIEF.md
# Command-Sequenced Packet Pattern Generator

This block drives test traffic into the transmit side of a serial link tester. A host first fills two local stores through a plain register write port: a command store of 64 entries, and a symbol store that holds packet contents already coded as 10-bit line symbols. A third write sets the command index at which execution begins. Every command is a small step. It either sends one stored packet a given number of times on one output lane, or it holds off for a given number of cycles. It may also halt the run. When a command is done, control falls through to the following index or jumps to a target index that the command itself carries. A program can therefore run a fixed preamble and then loop forever over its tail.

Each output lane presents one 10-bit symbol per clock to a serializer. A lane that is not carrying packet symbols carries a fixed idle symbol, so the link stays trained between packets. Once a packet copy has started, it always completes. A stop request ends the run only at a copy boundary. The host can read the command index in use and a busy flag.

Top module: `pattern_seq_gen`

## Requirements
- R1: After reset every lane outputs the idle symbol (parameter IDLE_SYM, default 10'h0F8), `busy` is 0 and `cur_idx` is 0.
- R2: A host write with `wr_sel`=0 stores `wr_data[47:0]` as the command at index `wr_addr[5:0]`. With `wr_sel`=1 it stores the symbol-store word at `wr_addr`, where symbol address 2a is taken from bits [9:0] and 2a+1 from bits [25:16]. With `wr_sel`=2 it loads the start index from `wr_data[5:0]`.
- R3: While idle, a `start` pulse begins execution at the stored start index and raises `busy`. A `start` pulse while `busy` is high has no effect.
- R4: A command with opcode bits [1:0]=1 sends the symbols at addresses [47:37], [47:37]+1, and onward, for a length taken from field [36:27], repeated as many times as field [26:11] says. It drives them on the lane given by bits [10:9], where lane p occupies `tx_sym[10p+9:10p]`. Copies follow each other with no idle symbol between them, and all other lanes stay idle.
- R5: Between the last symbol of one command and the first symbol of the next transmit command there is exactly one idle cycle.
- R6: A command with opcode 2 pauses for T = field [26:11] cycles, so that the idle gap between the surrounding packets is T+2 cycles. T=0 is accepted and gives a gap of 2.
- R7: When bit [8] of a finished command is 1, execution continues at the index in bits [7:2]. Otherwise it continues at the index plus one.
- R8: Opcode 0 ends the run. `busy` falls, all lanes go idle and `cur_idx` keeps the halting index.
- R9: A `stop` pulse during a packet copy lets that copy finish, including when it lands on the copy's last symbol. No further copy or command follows. A `stop` during a pause ends the run at once. In both cases `cur_idx` keeps the index of the interrupted command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Host write strobe |
| wr_sel | input | 2 | Write target: 0 command, 1 symbol word, 2 start index |
| wr_addr | input | DATA_AW | Command index or symbol-store word address |
| wr_data | input | 48 | Write data |
| start | input | 1 | Begin execution pulse |
| stop | input | 1 | End execution at the next copy boundary |
| busy | output | 1 | High while a program runs |
| cur_idx | output | 6 | Index of the command in use |
| tx_sym | output | 10*NPORTS | Per-lane output symbols, lane p in bits [10p+9:10p] |

## Verification
The stop request and the end of a packet copy can fall into the same cycle. That is the point where a late stop could either be lost or chop a burst. The bench watches the lanes and raises `stop` just after it sees the second-to-last symbol of a copy in a looping program, so the request is sampled on the cycle that sends the final symbol. The bench then expects that final symbol and nothing after it, although the command asks for a further copy. It repeats the exercise with a stop in mid-copy and with a stop during a pause.

// File: rtl/pg_pkg.sv
package pg_pkg;
  localparam int SYM_W   = 10;
  localparam int CMD_AW  = 6;
  localparam int SADDR_W = 11;
  localparam int LEN_W   = 10;
  localparam int CNT_W   = 16;
  localparam int PORT_W  = 2;
  localparam int CMD_W   = SADDR_W + LEN_W + CNT_W + PORT_W + 1 + CMD_AW + 2;

  typedef enum logic [1:0] {
    OP_HALT = 2'd0,
    OP_TX   = 2'd1,
    OP_WAIT = 2'd2,
    OP_RSVD = 2'd3
  } op_e;

  typedef struct packed {
    logic [SADDR_W-1:0] saddr;
    logic [LEN_W-1:0]   len;
    logic [CNT_W-1:0]   count;
    logic [PORT_W-1:0]  port;
    logic               jump;
    logic [CMD_AW-1:0]  target;
    op_e                op;
  } cmd_t;

  typedef enum logic [1:0] {
    S_IDLE,
    S_EXEC,
    S_SEND,
    S_WAIT
  } seq_st_e;
endpackage

// File: rtl/pg_cmd_store.sv
module pg_cmd_store
  import pg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              wr_cmd_i,
  input  logic              wr_idx_i,
  input  logic [CMD_AW-1:0] wr_addr_i,
  input  logic [CMD_W-1:0]  wr_data_i,
  input  logic [CMD_AW-1:0] rd_addr_i,
  output cmd_t              cmd_o,
  output logic [CMD_AW-1:0] start_idx_o
);
  localparam int DEPTH = 1 << CMD_AW;

  logic [CMD_W-1:0]  mem_q [DEPTH];
  logic [CMD_AW-1:0] start_q;

  always_ff @(posedge clk) begin
    if (wr_cmd_i) mem_q[wr_addr_i] <= wr_data_i;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)       start_q <= '0;
    else if (wr_idx_i) start_q <= wr_data_i[CMD_AW-1:0];
  end

  assign cmd_o       = cmd_t'(mem_q[rd_addr_i]);
  assign start_idx_o = start_q;

  // R2: the start index register takes the written value
  a_r2_start_idx_load: assert property (@(posedge clk) disable iff (!rst_ni)
    wr_idx_i |=> start_idx_o == $past(wr_data_i[CMD_AW-1:0]));
endmodule

// File: rtl/pg_sym_store.sv
module pg_sym_store
  import pg_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic             clk,
  input  logic             wr_en_i,
  input  logic [AW-1:0]    wr_addr_i,
  input  logic [SYM_W-1:0] wr_lo_i,
  input  logic [SYM_W-1:0] wr_hi_i,
  input  logic [AW:0]      rd_addr_i,
  output logic [SYM_W-1:0] rd_sym_o
);
  localparam int WORDS = 1 << AW;

  logic [2*SYM_W-1:0] mem_q [WORDS];
  logic [2*SYM_W-1:0] word;

  always_ff @(posedge clk) begin
    if (wr_en_i) mem_q[wr_addr_i] <= {wr_hi_i, wr_lo_i};
  end

  assign word     = mem_q[rd_addr_i[AW:1]];
  assign rd_sym_o = rd_addr_i[0] ? word[2*SYM_W-1:SYM_W] : word[SYM_W-1:0];
endmodule

// File: rtl/pg_sequencer.sv
module pg_sequencer
  import pg_pkg::*;
(
  input  logic               clk,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               stop_i,
  input  logic [CMD_AW-1:0]  start_idx_i,
  input  cmd_t               cmd_i,
  output logic [CMD_AW-1:0]  pc_o,
  output logic               busy_o,
  output logic               send_v_o,
  output logic [PORT_W-1:0]  send_port_o,
  output logic [SADDR_W-1:0] sym_addr_o
);
  seq_st_e            st_q, st_d;
  logic [CMD_AW-1:0]  pc_q, pc_d, next_pc;
  logic [SADDR_W-1:0] ptr_q, ptr_d, base_q, base_d;
  logic [LEN_W-1:0]   left_q, left_d, len_q, len_d;
  logic [CNT_W-1:0]   rep_q, rep_d, wcnt_q, wcnt_d;
  logic [PORT_W-1:0]  port_q, port_d;
  logic               stop_q, stop_d;

  assign next_pc = cmd_i.jump ? cmd_i.target : pc_q + 1'b1;

  always_comb begin
    st_d   = st_q;
    pc_d   = pc_q;
    ptr_d  = ptr_q;
    base_d = base_q;
    left_d = left_q;
    len_d  = len_q;
    rep_d  = rep_q;
    wcnt_d = wcnt_q;
    port_d = port_q;
    stop_d = stop_q | (stop_i & (st_q != S_IDLE));
    unique case (st_q)
      S_IDLE: begin
        if (start_i) begin
          st_d   = S_EXEC;
          pc_d   = start_idx_i;
          stop_d = 1'b0;
        end
      end
      S_EXEC: begin
        if (stop_d) begin
          st_d = S_IDLE;
        end else begin
          case (cmd_i.op)
            OP_TX: begin
              if (cmd_i.count != '0 && cmd_i.len != '0) begin
                st_d   = S_SEND;
                ptr_d  = cmd_i.saddr;
                base_d = cmd_i.saddr;
                left_d = cmd_i.len;
                len_d  = cmd_i.len;
                rep_d  = cmd_i.count;
                port_d = cmd_i.port;
              end else begin
                pc_d = next_pc;
              end
            end
            OP_WAIT: begin
              if (cmd_i.count != '0) begin
                st_d   = S_WAIT;
                wcnt_d = cmd_i.count;
              end else begin
                pc_d = next_pc;
              end
            end
            default: st_d = S_IDLE;
          endcase
        end
      end
      S_SEND: begin
        if (left_q == LEN_W'(1)) begin
          if (stop_d) begin
            st_d = S_IDLE;
          end else if (rep_q == CNT_W'(1)) begin
            st_d = S_EXEC;
            pc_d = next_pc;
          end else begin
            rep_d  = rep_q - 1'b1;
            ptr_d  = base_q;
            left_d = len_q;
          end
        end else begin
          ptr_d  = ptr_q + 1'b1;
          left_d = left_q - 1'b1;
        end
      end
      S_WAIT: begin
        if (stop_d) begin
          st_d = S_IDLE;
        end else if (wcnt_q == CNT_W'(1)) begin
          st_d = S_EXEC;
          pc_d = next_pc;
        end else begin
          wcnt_d = wcnt_q - 1'b1;
        end
      end
    endcase
    if (st_d == S_IDLE) stop_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      pc_q   <= '0;
      ptr_q  <= '0;
      base_q <= '0;
      left_q <= '0;
      len_q  <= '0;
      rep_q  <= '0;
      wcnt_q <= '0;
      port_q <= '0;
      stop_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      pc_q   <= pc_d;
      ptr_q  <= ptr_d;
      base_q <= base_d;
      left_q <= left_d;
      len_q  <= len_d;
      rep_q  <= rep_d;
      wcnt_q <= wcnt_d;
      port_q <= port_d;
      stop_q <= stop_d;
    end
  end

  assign pc_o        = pc_q;
  assign busy_o      = (st_q != S_IDLE);
  assign send_v_o    = (st_q == S_SEND);
  assign send_port_o = port_q;
  assign sym_addr_o  = ptr_q;

  // R3: an accepted start loads the start index and raises busy
  a_r3_start_loads: assert property (@(posedge clk) disable iff (!rst_ni)
    (st_q == S_IDLE && start_i) |=> (busy_o && pc_q == $past(start_idx_i)));
  // R9: inside a copy the next symbol always follows, stop or not
  a_r9_no_truncate: assert property (@(posedge clk) disable iff (!rst_ni)
    (st_q == S_SEND && left_q != LEN_W'(1)) |=> (st_q == S_SEND && ptr_q == $past(ptr_q) + 1'b1));
  // R6: a pause counts down one per cycle
  a_r6_wait_step: assert property (@(posedge clk) disable iff (!rst_ni)
    (st_q == S_WAIT && wcnt_q != CNT_W'(1) && !stop_q && !stop_i)
      |=> (st_q == S_WAIT && wcnt_q == $past(wcnt_q) - 1'b1));
  // R8: a halt command ends the run and keeps the index
  a_r8_halt_stops: assert property (@(posedge clk) disable iff (!rst_ni)
    (st_q == S_EXEC && cmd_i.op == OP_HALT) |=> (!busy_o && $stable(pc_q)));
endmodule

// File: rtl/pg_tx_lanes.sv
module pg_tx_lanes
  import pg_pkg::*;
#(
  parameter int               NPORTS   = 4,
  parameter logic [SYM_W-1:0] IDLE_SYM = 10'h0F8
) (
  input  logic                    clk,
  input  logic                    rst_ni,
  input  logic                    send_v_i,
  input  logic [PORT_W-1:0]       send_port_i,
  input  logic [SYM_W-1:0]        send_sym_i,
  output logic [NPORTS*SYM_W-1:0] tx_o
);
  for (genvar p = 0; p < NPORTS; p++) begin : g_lane
    logic             hit;
    logic [SYM_W-1:0] sym_q;

    assign hit = send_v_i && (send_port_i == PORT_W'(p));

    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni) sym_q <= IDLE_SYM;
      else         sym_q <= hit ? send_sym_i : IDLE_SYM;
    end

    assign tx_o[p*SYM_W +: SYM_W] = sym_q;

    // R4: a lane not addressed by the sequencer carries idle next cycle
    a_r4_lane_quiet: assert property (@(posedge clk) disable iff (!rst_ni)
      !(send_v_i && send_port_i == PORT_W'(p)) |=> tx_o[p*SYM_W +: SYM_W] == IDLE_SYM);
  end
endmodule

// File: rtl/pattern_seq_gen.sv
module pattern_seq_gen
  import pg_pkg::*;
#(
  parameter int               NPORTS   = 4,
  parameter int               DATA_AW  = 10,
  parameter logic [SYM_W-1:0] IDLE_SYM = 10'h0F8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [1:0]              wr_sel,
  input  logic [DATA_AW-1:0]      wr_addr,
  input  logic [CMD_W-1:0]        wr_data,
  input  logic                    start,
  input  logic                    stop,
  output logic                    busy,
  output logic [CMD_AW-1:0]       cur_idx,
  output logic [NPORTS*SYM_W-1:0] tx_sym
);
  logic [1:0]         rst_sync_q;
  logic               rst_ni;
  cmd_t               cmd;
  logic [CMD_AW-1:0]  start_idx;
  logic               send_v;
  logic [PORT_W-1:0]  send_port;
  logic [SADDR_W-1:0] sym_addr;
  logic [SYM_W-1:0]   send_sym;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  pg_cmd_store u_cmd (
    .clk         (clk),
    .rst_ni      (rst_ni),
    .wr_cmd_i    (wr_en && wr_sel == 2'd0),
    .wr_idx_i    (wr_en && wr_sel == 2'd2),
    .wr_addr_i   (wr_addr[CMD_AW-1:0]),
    .wr_data_i   (wr_data),
    .rd_addr_i   (cur_idx),
    .cmd_o       (cmd),
    .start_idx_o (start_idx)
  );

  pg_sym_store #(.AW(DATA_AW)) u_sym (
    .clk       (clk),
    .wr_en_i   (wr_en && wr_sel == 2'd1),
    .wr_addr_i (wr_addr),
    .wr_lo_i   (wr_data[SYM_W-1:0]),
    .wr_hi_i   (wr_data[16 +: SYM_W]),
    .rd_addr_i (sym_addr[DATA_AW:0]),
    .rd_sym_o  (send_sym)
  );

  pg_sequencer u_seq (
    .clk         (clk),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .stop_i      (stop),
    .start_idx_i (start_idx),
    .cmd_i       (cmd),
    .pc_o        (cur_idx),
    .busy_o      (busy),
    .send_v_o    (send_v),
    .send_port_o (send_port),
    .sym_addr_o  (sym_addr)
  );

  pg_tx_lanes #(.NPORTS(NPORTS), .IDLE_SYM(IDLE_SYM)) u_lanes (
    .clk         (clk),
    .rst_ni      (rst_ni),
    .send_v_i    (send_v),
    .send_port_i (send_port),
    .send_sym_i  (send_sym),
    .tx_o        (tx_sym)
  );
endmodule

// File: tb/pattern_seq_gen_bench.sv
module pattern_seq_gen_bench;
  localparam int          NP   = 4;
  localparam logic [9:0]  IDLE = 10'h0F8;

  typedef struct {
    int         port;
    logic [9:0] sym;
    int         gap;
    string      tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [1:0]  wr_sel;
  logic [9:0]  wr_addr;
  logic [47:0] wr_data;
  logic        start;
  logic        stop;
  logic        busy;
  logic [5:0]  cur_idx;
  logic [39:0] tx_sym;

  int   checks   = 0;
  int   failures = 0;
  int   idle_run = 0;
  exp_t q[$];

  always #2 clk = ~clk;

  pattern_seq_gen u_pattern_seq_gen (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_addr(wr_addr),
    .wr_data(wr_data), .start(start), .stop(stop), .busy(busy), .cur_idx(cur_idx),
    .tx_sym(tx_sym)
  );

  function automatic logic [9:0] psym(int a);
    return {1'b1, 9'(a)};
  endfunction

  function automatic logic [47:0] mk(int op, int sa, int len, int cnt, int port, int jmp, int tgt);
    return {11'(sa), 10'(len), 16'(cnt), 2'(port), 1'(jmp), 6'(tgt), 2'(op)};
  endfunction

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic host_wr(int sel, int addr, logic [47:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 2'(sel); wr_addr = 10'(addr); wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  // driver side of the scoreboard: push every symbol a transmit command produces
  task automatic expect_tx(int sa, int len, int cnt, int port, int gap, string tag);
    for (int r = 0; r < cnt; r++) begin
      for (int i = 0; i < len; i++) begin
        exp_t e;
        e.port = port;
        e.sym  = psym(sa + i);
        e.gap  = (r == 0 && i == 0) ? gap : 0;
        e.tag  = (r == 0 && i == 0) ? tag : "R4";
        q.push_back(e);
      end
    end
  endtask

  task automatic wait_sym(logic [9:0] s);
    bit seen = 1'b0;
    for (int n = 0; n < 5000 && !seen; n++) begin
      @(negedge clk);
      for (int p = 0; p < NP; p++) if (tx_sym[p*10 +: 10] == s) seen = 1'b1;
    end
    check(seen, "R7", "symbol never seen", 0, int'(s));
  endtask

  task automatic stop_and_trim(int keep);
    stop = 1'b1;
    @(posedge clk); #1;
    stop = 1'b0;
    while (q.size() > keep) void'(q.pop_back());
  endtask

  task automatic drain(string tag);
    for (int n = 0; n < 5000 && q.size() != 0; n++) @(negedge clk);
    repeat (20) @(negedge clk);
    check(q.size() == 0, tag, "symbols missing", q.size(), 0);
  endtask

  // monitor side of the scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      int nact;
      nact = 0;
      for (int p = 0; p < NP; p++) begin
        logic [9:0] s;
        s = tx_sym[p*10 +: 10];
        if (s != IDLE) begin
          nact++;
          if (q.size() == 0) begin
            check(1'b0, "R9", $sformatf("unexpected symbol on lane %0d", p), int'(s), int'(IDLE));
          end else begin
            exp_t e;
            e = q.pop_front();
            check(e.port == p, "R4", "lane", p, e.port);
            check(e.sym == s, "R2", "symbol", int'(s), int'(e.sym));
            if (e.gap >= 0) check(e.gap == idle_run, e.tag, "idle gap", idle_run, e.gap);
          end
        end
      end
      if (nact > 1) check(1'b0, "R4", "lanes active together", nact, 1);
      if (nact == 0) idle_run++;
      else           idle_run = 0;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_sel = '0; wr_addr = '0; wr_data = '0;
    start = 1'b0; stop = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check(tx_sym == {NP{IDLE}}, "R1", "lanes idle after reset", 0, 0);
    check(busy == 1'b0, "R1", "busy after reset", busy, 0);
    check(cur_idx == 6'd0, "R1", "index after reset", cur_idx, 0);

    // R2 symbol store: even address in [9:0], odd in [25:16]
    for (int w = 0; w < 260; w++)
      host_wr(1, w, {22'd0, psym(2*w+1), 6'd0, psym(2*w)});

    // program A: pauses, jump, halt (R3 R5 R6 R7 R8)
    host_wr(0, 2,  mk(1, 10, 5, 3, 1, 0, 0));
    host_wr(0, 3,  mk(2, 0, 0, 4, 0, 0, 0));
    host_wr(0, 4,  mk(1, 40, 3, 1, 2, 0, 0));
    host_wr(0, 5,  mk(2, 0, 0, 0, 0, 0, 0));
    host_wr(0, 6,  mk(1, 7, 4, 2, 0, 1, 9));
    host_wr(0, 7,  mk(1, 120, 3, 1, 3, 0, 0));
    host_wr(0, 8,  mk(1, 130, 3, 1, 3, 0, 0));
    host_wr(0, 9,  mk(1, 100, 2, 1, 3, 0, 0));
    host_wr(0, 10, mk(0, 0, 0, 0, 0, 0, 0));
    host_wr(2, 0, 48'd2);
    expect_tx(10, 5, 3, 1, -1, "R3");
    expect_tx(40, 3, 1, 2, 6, "R6");
    expect_tx(7, 4, 2, 0, 2, "R6");
    expect_tx(100, 2, 1, 3, 1, "R7");
    pulse_start();
    @(negedge clk);
    check(busy == 1'b1, "R3", "busy after start", busy, 1);
    wait_sym(psym(11));
    host_wr(2, 0, 48'd7);
    pulse_start();                       // R3: ignored while running
    drain("R8");
    check(busy == 1'b0, "R8", "busy after halt", busy, 0);
    check(cur_idx == 6'd10, "R8", "index after halt", cur_idx, 10);

    // looping program; stop lands on the last symbol of a copy (R5 R7 R9)
    host_wr(0, 20, mk(1, 200, 6, 2, 0, 0, 0));
    host_wr(0, 21, mk(1, 300, 3, 1, 1, 0, 0));
    host_wr(0, 22, mk(1, 400, 4, 2, 2, 0, 0));
    host_wr(0, 23, mk(1, 500, 5, 1, 3, 1, 22));
    host_wr(2, 0, 48'd20);
    expect_tx(200, 6, 2, 0, -1, "R3");
    expect_tx(300, 3, 1, 1, 1, "R5");
    for (int k = 0; k < 3; k++) begin
      expect_tx(400, 4, 2, 2, 1, "R5");
      expect_tx(500, 5, 1, 3, 1, "R7");
    end
    pulse_start();
    wait_sym(psym(504));
    wait_sym(psym(402));
    stop_and_trim(1);
    drain("R9");
    check(busy == 1'b0, "R9", "busy after stop at copy end", busy, 0);
    check(cur_idx == 6'd22, "R9", "index after stop", cur_idx, 22);

    // stop in mid-copy: the copy completes, the second copy never starts (R9)
    expect_tx(200, 6, 2, 0, -1, "R3");
    expect_tx(300, 3, 1, 1, 1, "R5");
    pulse_start();
    wait_sym(psym(201));
    stop_and_trim(4);
    drain("R9");
    check(busy == 1'b0, "R9", "busy after mid-copy stop", busy, 0);
    check(cur_idx == 6'd20, "R9", "index after mid-copy stop", cur_idx, 20);

    // stop during a long pause ends the run at once (R9)
    host_wr(0, 30, mk(2, 0, 0, 1000, 0, 0, 0));
    host_wr(0, 31, mk(1, 250, 2, 1, 0, 0, 0));
    host_wr(2, 0, 48'd30);
    pulse_start();
    repeat (20) @(negedge clk);
    check(busy == 1'b1, "R6", "busy during pause", busy, 1);
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    repeat (2) @(negedge clk);
    check(busy == 1'b0, "R9", "busy after stop in pause", busy, 0);
    check(cur_idx == 6'd30, "R9", "index after stop in pause", cur_idx, 30);
    drain("R9");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule